// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block keeps the transfer count of one DMA channel. It holds two values. The first is a programmed length, called the reload value. The second is a live counter of the transfers still to be done in the current sequence. The length is counted in bus transfers, not bytes. When transfers are wider than one byte, the byte total is the count times the transfer size.

Software sets the length through a register write. A normal write only changes the reload value. A write through the trigger alias stores the length and starts a sequence with it in the same cycle. A separate trigger input also starts a sequence. It copies the reload value into the live counter, so repeated triggers run the same length.

Each completed write transfer takes one off the live count. The channel drops busy and raises a one-cycle done pulse when the count reaches zero. The count register always reads back the live counter. A debug output always shows the reload value.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, the read data, the debug reload output, busy and done are all zero.
- R2: A write with `wr_trig_sel` low stores `wr_data` as the reload value, which appears on `dbg_reload` the next cycle. The live count on `rd_data` stays unchanged, even in the middle of a sequence.
- R3: A pulse on `trig_in` copies the reload value into the live counter and sets busy when that value is non-zero. Repeated pulses restart the same length.
- R4: While busy, each cycle with `xfer_done` high lowers `rd_data` by one on the next cycle, so `rd_data` shows the transfers remaining.
- R5: Once the completion that brings the count to zero has been registered, busy is low, `rd_data` is zero and `done` is high. One cycle later, `done` is low again.
- R6: A write with `wr_trig_sel` high loads `wr_data` into both the live counter and the reload value in one cycle and starts a sequence.
- R7: A start whose length is zero sets no busy. It gives only a single-cycle done pulse, and `rd_data` is zero.
- R8: While idle, `xfer_done` has no effect: busy and done stay low and `rd_data` holds its value.
- R9: A start takes priority over a coincident `xfer_done`, and a start while busy restarts from the new length. When a trigger-alias write and `trig_in` coincide, the written value is the length used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for the count register |
| wr_trig_sel | input | 1 | 0 selects the normal alias, 1 selects the trigger alias |
| wr_data | input | CW | Write data (the transfer length) |
| trig_in | input | 1 | Trigger pulse that starts a sequence from the reload value |
| xfer_done | input | 1 | One write transfer completed this cycle |
| rd_data | output | CW | Count register read data (the live counter) |
| dbg_reload | output | CW | Reload value, readable at all times |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The countdown runs three ways: from the trigger input, from a trigger-alias write, and with a zero length. These separate copying the reload value, loading the new length directly, and the immediate-completion path. Normal writes made mid-sequence show that the reload value and the live count are kept apart. Coincident starts and completions, a restart while busy, and completions while idle check the priority order and that stray strobes are ignored.

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_trig_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          trig_in,
  input  logic          xfer_done,
  output logic [CW-1:0] rd_data,
  output logic [CW-1:0] dbg_reload,
  output logic          busy,
  output logic          done
);

  logic [CW-1:0] reload_q, live_q;
  logic          busy_q, done_q;

  wire           alias_wr  = wr_en & wr_trig_sel;
  wire           start     = alias_wr | trig_in;
  wire  [CW-1:0] start_len = alias_wr ? wr_data : reload_q;
  wire           step      = busy_q & xfer_done;
  wire           last      = step & (live_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      live_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (wr_en) reload_q <= wr_data;
      if (start) begin
        live_q <= start_len;
        busy_q <= (start_len != '0);
        done_q <= (start_len == '0);
      end else begin
        if (step) live_q <= live_q - CW'(1);
        if (last) busy_q <= 1'b0;
        done_q <= last;
      end
    end
  end

  assign rd_data    = live_q;
  assign dbg_reload = reload_q;
  assign busy       = busy_q;
  assign done       = done_q;

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && !start) |=> (rd_data == $past(rd_data) - CW'(1)));

  a_r2_normal_write_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_trig_sel && !trig_in && !xfer_done) |=> $stable(rd_data));

  a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data != '0));

  a_r6_alias_loads_both: assert property (@(posedge clk) disable iff (!rst_n)
    alias_wr |=> (rd_data == $past(wr_data) && dbg_reload == $past(wr_data)));

  a_r8_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rd_data) && !busy && !done));

  a_r7_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

// File: tb/dma_xfer_counter_tb.sv
module dma_xfer_counter_tb_top;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_trig_sel = 1'b0, trig_in = 1'b0, xfer_done = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data, dbg_reload;
  logic          busy, done;
  int            checks = 0, failures = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  dma_xfer_counter #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_trig_sel(wr_trig_sel),
    .wr_data(wr_data), .trig_in(trig_in), .xfer_done(xfer_done),
    .rd_data(rd_data), .dbg_reload(dbg_reload), .busy(busy), .done(done));

  task automatic chk(input string req, input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive for one clock edge starting at a negedge; returns at the following negedge.
  task automatic cyc(input logic en, input logic sel, input logic [CW-1:0] d, input logic tg, input logic xd);
    wr_en = en; wr_trig_sel = sel; wr_data = d; trig_in = tg; xfer_done = xd;
    @(negedge clk);
    wr_en = 1'b0; wr_trig_sel = 1'b0; wr_data = '0; trig_in = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n - 1; i++) cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk(req, "busy at end", CW'(busy), 0);
    chk(req, "done at end", CW'(done), 1);
    chk(req, "count at end", rd_data, 0);
    cyc(0, 0, 0, 0, 0);
    chk(req, "done drops", CW'(done), 0);
  endtask

  task automatic t_reset;
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "dbg_reload", dbg_reload, 0);
    chk("R1", "busy", CW'(busy), 0);
    chk("R1", "done", CW'(done), 0);
  endtask

  task automatic t_normal_write;
    cyc(1, 0, 5, 0, 0);
    chk("R2", "reload after write", dbg_reload, 5);
    chk("R2", "live untouched", rd_data, 0);
    chk("R2", "no start", CW'(busy), 0);
  endtask

  task automatic t_trigger_run;
    cyc(0, 0, 0, 1, 0);
    chk("R3", "live loaded", rd_data, 5);
    chk("R3", "busy set", CW'(busy), 1);
    for (int i = 4; i >= 1; i--) begin
      cyc(0, 0, 0, 0, 1);
      chk("R4", "remaining", rd_data, CW'(i));
    end
    cyc(0, 0, 0, 0, 0);
    chk("R4", "no strobe holds", rd_data, 1);
    drain(1, "R5");
  endtask

  task automatic t_repeat_and_midwrite;
    cyc(0, 0, 0, 1, 0);
    chk("R3", "repeat length", rd_data, 5);
    cyc(0, 0, 0, 0, 1);
    chk("R4", "after one", rd_data, 4);
    cyc(1, 0, 9, 0, 0);
    chk("R2", "midrun live kept", rd_data, 4);
    chk("R2", "midrun reload", dbg_reload, 9);
    chk("R2", "still busy", CW'(busy), 1);
    cyc(0, 0, 0, 1, 1);
    chk("R9", "restart beats completion", rd_data, 9);
    drain(9, "R5");
  endtask

  task automatic t_alias;
    cyc(1, 1, 3, 0, 0);
    chk("R6", "live", rd_data, 3);
    chk("R6", "reload", dbg_reload, 3);
    chk("R6", "busy", CW'(busy), 1);
    drain(3, "R6");
    cyc(0, 0, 0, 1, 0);
    chk("R3", "trigger reuses alias length", rd_data, 3);
    drain(3, "R3");
  endtask

  task automatic t_zero;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7", "busy", CW'(busy), 0);
    chk("R7", "done", CW'(done), 1);
    chk("R7", "count", rd_data, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7", "done one cycle", CW'(done), 0);
    cyc(1, 1, 0, 0, 0);
    chk("R7", "alias zero done", CW'(done), 1);
    chk("R7", "alias zero busy", CW'(busy), 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic t_idle_ignore;
    cyc(1, 0, 6, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 1);
      chk("R8", "busy idle", CW'(busy), 0);
      chk("R8", "done idle", CW'(done), 0);
      chk("R8", "count held", rd_data, 0);
    end
    chk("R8", "reload kept", dbg_reload, 6);
  endtask

  task automatic t_priority;
    cyc(1, 1, 2, 1, 0);
    chk("R9", "alias data wins", rd_data, 2);
    chk("R9", "reload from alias", dbg_reload, 2);
    drain(2, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal_write();
    t_trigger_run();
    t_repeat_and_midwrite();
    t_alias();
    t_zero();
    t_idle_ignore();
    t_priority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule